// File: doc/BRIEF.md
# Interrupt Entry and Context Save Unit

This unit sits beside the fetch logic of a small 8-bit controller core and decides when the core is diverted into its interrupt handler. Six raw request lines are edge-detected into a request register. While the global enable is set, any pending flag makes the unit load the program counter with a fixed vector, push the current next-PC value onto an eight-entry return stack, and drop the global enable so that handlers do not nest. A return command pops the stack, reloads the PC with the saved address and sets the enable again.

The global enable and the 3-bit stack pointer share one software register at address 0xDF. The request flags live in a second register at address 0xC8. The unit also keeps a one-entry shadow copy of the accumulator and the flag byte. A push command fills this copy and a pop command hands it back. On a pop, two status bits of the flag byte keep the live value that the core presents.

Top module: `irq_entry`

## Requirements
- R1: After reset, address 0xDF reads 0x07 (enable 0 in bit 7, stack pointer 111 in bits 2..0), address 0xC8 reads 0x00, and pcLoad is 0.
- R2: A rising edge on reqIn[k] sets bit k+1 of the request register at 0xC8. A request line that stays high does not set its flag again after the flag has been cleared.
- R3: A write to 0xC8 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. Bits 0 and 7 of 0xC8 always read 0.
- R4: While the enable bit is 0, no entry occurs: pcLoad stays 0 and pending flags stay set.
- R5: When the enable is 1 and any flag is pending, one cycle later pcLoad is 1 and pcOut is 8, nextPc is stored at the current stack pointer, and the stack pointer decrements by 1.
- R6: Entry clears the enable bit and does not clear any flag. pcLoad is a one-cycle pulse, and no further entry happens until a return.
- R7: retiEn increments the stack pointer. One cycle later pcLoad is 1, pcOut holds the address saved by the matching entry, and the enable bit is 1.
- R8: The stack pointer wraps from 000 to 111 on entry and from 111 to 000 on return, with no error indication.
- R9: On entry, irqIndex captures the position (1..6) of the lowest-numbered pending flag bit in 0xC8.
- R10: pushEn stores accIn and flagIn into the shadow buffer. A later push overwrites it. accOut shows the stored accumulator, and a push in the same cycle as a pop does not change what that pop returns.
- R11: flagOut carries the stored flag byte in bits 5..0 and the live flagIn in bits 7 and 6.
- R12: A write to 0xDF loads the enable from bit 7 and the stack pointer from bits 2..0. Bits 6..3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| reqIn | input | 6 | Raw interrupt request lines |
| retiEn | input | 1 | Return-from-interrupt command |
| nextPc | input | 12 | Return address offered by the core |
| pcLoad | output | 1 | PC redirect strobe |
| pcOut | output | 12 | PC redirect target |
| irqIndex | output | 3 | Lowest pending source captured at entry |
| pushEn | input | 1 | Save accumulator and flags |
| popEn | input | 1 | Restore request (outputs valid while high) |
| accIn | input | 8 | Live accumulator |
| flagIn | input | 8 | Live flag byte |
| accOut | output | 8 | Restored accumulator |
| flagOut | output | 8 | Restored flag byte |

## Verification
The bench aims at the stack pointer wrapping at both ends. A design that saturates instead of wrapping would return to the wrong address. It also checks that a request line held high stays cleared after software clears its flag, because a level-sensitive design would re-raise the flag and re-enter at once. When two flags are pending it checks that irqIndex picks the lower one, so an inverted priority scan shows up. The shadow cases cover a double push, which must overwrite the first, a pop together with a push, which must return the old contents, and the two live status bits, which a design that restores the whole byte would get wrong.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef struct packed {
    logic enter;
    logic leave;
    logic spWrite;
    logic save;
  } irqStrobe_t;
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int NUM_SRC  = 6,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 8,
  parameter int REQ_ADDR = 8'hC8,
  parameter int STK_ADDR = 8'hDF,
  localparam int IDX_W   = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               retiEn,
  input  logic               pushEn,
  output irqStrobe_t         strobe,
  output logic               gie,
  output logic [NUM_SRC-1:0] flags,
  output logic [IDX_W-1:0]   irqIndex
);
  logic [NUM_SRC-1:0] reqPrev, rise, keepMask;
  logic [IDX_W-1:0]   firstIdx;
  logic               wrReq, wrStk;

  assign wrReq    = regWrEn && (regAddr == ADDR_W'(REQ_ADDR));
  assign wrStk    = regWrEn && (regAddr == ADDR_W'(STK_ADDR));
  assign rise     = reqIn & ~reqPrev;
  assign keepMask = wrReq ? regWrData[NUM_SRC:1] : '1;

  // lowest-numbered pending flag wins the index
  always_comb begin
    firstIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (flags[i]) firstIdx = IDX_W'(i + 1);
  end

  always_comb begin
    strobe.leave   = retiEn;
    strobe.enter   = gie && (|flags) && !retiEn;
    strobe.spWrite = wrStk;
    strobe.save    = pushEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev  <= '0;
      flags    <= '0;
      gie      <= 1'b0;
      irqIndex <= '0;
    end else begin
      reqPrev <= reqIn;
      flags   <= (flags & keepMask) | rise;
      if (strobe.enter)      gie <= 1'b0;
      else if (strobe.leave) gie <= 1'b1;
      else if (wrStk)        gie <= regWrData[DATA_W-1];
      if (strobe.enter) irqIndex <= firstIdx;
    end
  end
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int SP_W      = 3,
  parameter int DATA_W    = 8,
  parameter int VECTOR    = 8,
  parameter int KEEP_MASK = 8'hC0,
  localparam int DEPTH    = 1 << SP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        strobe,
  input  logic [SP_W-1:0]   spWrData,
  input  logic [PC_W-1:0]   nextPc,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] flagIn,
  output logic [SP_W-1:0]   sp,
  output logic              pcLoad,
  output logic [PC_W-1:0]   pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] flagOut
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(KEEP_MASK);

  logic [PC_W-1:0]   stack [DEPTH];
  logic [SP_W-1:0]   spUp;
  logic [DATA_W-1:0] shAcc, shFlag;

  assign spUp = sp + SP_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sp <= '1;
    else if (strobe.enter)   sp <= sp - SP_W'(1);
    else if (strobe.leave)   sp <= spUp;
    else if (strobe.spWrite) sp <= spWrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.enter) stack[sp] <= nextPc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcLoad <= 1'b0;
      pcOut  <= '0;
    end else begin
      pcLoad <= strobe.enter | strobe.leave;
      if (strobe.enter)      pcOut <= PC_W'(VECTOR);
      else if (strobe.leave) pcOut <= stack[spUp];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shAcc  <= '0;
      shFlag <= '0;
    end else if (strobe.save) begin
      shAcc  <= accIn;
      shFlag <= flagIn;
    end
  end

  assign accOut  = shAcc;
  assign flagOut = (shFlag & ~KEEP) | (flagIn & KEEP);
endmodule

// File: rtl/irq_entry.sv
module irq_entry
  import irq_entry_pkg::*;
#(
  parameter int NUM_SRC   = 6,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int PC_W      = 12,
  parameter int SP_W      = 3,
  parameter int VECTOR    = 8,
  parameter int KEEP_MASK = 8'hC0,
  parameter int REQ_ADDR  = 8'hC8,
  parameter int STK_ADDR  = 8'hDF,
  localparam int IDX_W    = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               retiEn,
  input  logic [PC_W-1:0]    nextPc,
  output logic               pcLoad,
  output logic [PC_W-1:0]    pcOut,
  output logic [IDX_W-1:0]   irqIndex,
  input  logic               pushEn,
  input  logic               popEn,
  input  logic [DATA_W-1:0]  accIn,
  input  logic [DATA_W-1:0]  flagIn,
  output logic [DATA_W-1:0]  accOut,
  output logic [DATA_W-1:0]  flagOut
);
  irqStrobe_t         strobe;
  logic               gie;
  logic [SP_W-1:0]    sp;
  logic [NUM_SRC-1:0] flags;

  irq_entry_ctrl #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .REQ_ADDR(REQ_ADDR), .STK_ADDR(STK_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .reqIn(reqIn), .retiEn(retiEn), .pushEn(pushEn),
    .strobe(strobe), .gie(gie), .flags(flags), .irqIndex(irqIndex)
  );

  irq_entry_dp #(
    .PC_W(PC_W), .SP_W(SP_W), .DATA_W(DATA_W),
    .VECTOR(VECTOR), .KEEP_MASK(KEEP_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .spWrData(regWrData[SP_W-1:0]),
    .nextPc(nextPc), .accIn(accIn), .flagIn(flagIn), .sp(sp),
    .pcLoad(pcLoad), .pcOut(pcOut), .accOut(accOut), .flagOut(flagOut)
  );

  always_comb begin
    if (regAddr == ADDR_W'(STK_ADDR))
      regRdData = {gie, {(DATA_W-1-SP_W){1'b0}}, sp};
    else if (regAddr == ADDR_W'(REQ_ADDR))
      regRdData = DATA_W'({flags, 1'b0});
    else
      regRdData = '0;
  end

  logic unusedPop;
  assign unusedPop = popEn;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int DATA_W    = 8,
  parameter int PC_W      = 12,
  parameter int SP_W      = 3,
  parameter int VECTOR    = 8,
  parameter int KEEP_MASK = 8'hC0
) (
  input logic              clk,
  input logic              rstN,
  input logic              retiEn,
  input logic              popEn,
  input logic [DATA_W-1:0] flagIn,
  input logic [DATA_W-1:0] flagOut,
  input logic              pcLoad,
  input logic [PC_W-1:0]   pcOut,
  input logic              gie,
  input logic [SP_W-1:0]   sp,
  input logic              enter
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(KEEP_MASK);

  AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    enter |=> (pcLoad && pcOut == PC_W'(VECTOR))); // R5

  AST_SP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    enter |=> (sp == SP_W'($past(sp) - SP_W'(1)))); // R8

  AST_SP_UP: assert property (@(posedge clk) disable iff (!rstN)
    retiEn |=> (sp == SP_W'($past(sp) + SP_W'(1)))); // R7

  AST_GATED_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && !$past(retiEn)) |-> ($past(gie) && !gie)); // R4

  AST_LIVE_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    popEn |-> ((flagOut & KEEP) == (flagIn & KEEP))); // R11
endmodule

bind irq_entry irq_entry_chk #(
  .DATA_W(DATA_W), .PC_W(PC_W), .SP_W(SP_W), .VECTOR(VECTOR), .KEEP_MASK(KEEP_MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .retiEn(retiEn), .popEn(popEn), .flagIn(flagIn),
  .flagOut(flagOut), .pcLoad(pcLoad), .pcOut(pcOut), .gie(gie), .sp(sp),
  .enter(strobe.enter)
);

// File: tb/irq_entry_bench.sv
module irq_entry_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [5:0]  reqIn = '0;
  logic        retiEn = 1'b0;
  logic [11:0] nextPc = '0;
  logic        pcLoad;
  logic [11:0] pcOut;
  logic [2:0]  irqIndex;
  logic        pushEn = 1'b0;
  logic        popEn = 1'b0;
  logic [7:0]  accIn = '0;
  logic [7:0]  flagIn = '0;
  logic [7:0]  accOut;
  logic [7:0]  flagOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_entry u_irq_entry (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqIn(reqIn),
    .retiEn(retiEn), .nextPc(nextPc), .pcLoad(pcLoad), .pcOut(pcOut),
    .irqIndex(irqIndex), .pushEn(pushEn), .popEn(popEn), .accIn(accIn),
    .flagIn(flagIn), .accOut(accOut), .flagOut(flagOut)
  );

  // {push, pop, acc, flagIn, expAcc, expFlag}; checked only on pop rows
  localparam logic [33:0] VEC [8] = '{
    {1'b1, 1'b0, 8'hA5, 8'h3F, 8'h00, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'hC0, 8'hA5, 8'hFF},
    {1'b0, 1'b1, 8'h00, 8'h00, 8'hA5, 8'h3F},
    {1'b1, 1'b0, 8'h11, 8'hF2, 8'h00, 8'h00},
    {1'b1, 1'b0, 8'h22, 8'h05, 8'h00, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h80, 8'h22, 8'h85},
    {1'b1, 1'b1, 8'h33, 8'h41, 8'h22, 8'h45},
    {1'b0, 1'b1, 8'h00, 8'h00, 8'h33, 8'h01}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] addr, input logic [7:0] data);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [7:0] addr, input logic [7:0] exp);
    regAddr = addr;
    #1;
    check(req, 32'(regRdData), 32'(exp));
  endtask

  task automatic ret();
    retiEn = 1'b1;
    tick();
    retiEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    rdCheck("R1 stack reg", 8'hDF, 8'h07);
    rdCheck("R1 request reg", 8'hC8, 8'h00);
    check("R1 pcLoad", 32'(pcLoad), 32'd0);

    // shadow buffer vectors
    for (int i = 0; i < 8; i++) begin
      {pushEn, popEn, accIn, flagIn} = VEC[i][33:16];
      #1;
      if (popEn) begin
        check("R10 accOut", 32'(accOut), 32'(VEC[i][15:8]));
        check("R11 flagOut", 32'(flagOut), 32'(VEC[i][7:0]));
      end
      tick();
    end
    pushEn = 1'b0; popEn = 1'b0;

    // R2 / R4: flag sets on edge, no entry while disabled
    reqIn[2] = 1'b1;
    tick();
    rdCheck("R2 edge sets bit3", 8'hC8, 8'h08);
    repeat (3) tick();
    check("R4 no entry", 32'(pcLoad), 32'd0);
    rdCheck("R4 flag pending", 8'hC8, 8'h08);

    // R3: write-1 keeps, write-0 clears; held line does not re-set
    wrReg(8'hC8, 8'hFF);
    rdCheck("R3 write one keeps", 8'hC8, 8'h08);
    wrReg(8'hC8, 8'h00);
    rdCheck("R3 write zero clears", 8'hC8, 8'h00);
    tick();
    rdCheck("R2 level no reset", 8'hC8, 8'h00);
    reqIn[2] = 1'b0;

    // entry with two pending sources
    reqIn[4] = 1'b1; reqIn[1] = 1'b1; nextPc = 12'h123;
    tick();
    rdCheck("R2 two flags", 8'hC8, 8'h24);
    wrReg(8'hDF, 8'h87);
    rdCheck("R12 write stack reg", 8'hDF, 8'h87);
    tick();
    check("R5 pcLoad", 32'(pcLoad), 32'd1);
    check("R5 vector", 32'(pcOut), 32'h008);
    check("R9 lowest index", 32'(irqIndex), 32'd2);
    rdCheck("R6 gie clear sp dec", 8'hDF, 8'h06);
    rdCheck("R6 flags kept", 8'hC8, 8'h24);
    tick();
    check("R6 single pulse", 32'(pcLoad), 32'd0);
    reqIn[4] = 1'b0; reqIn[1] = 1'b0;

    // return, then immediate re-entry on remaining flag
    wrReg(8'hC8, 8'hFB);
    nextPc = 12'h200;
    ret();
    check("R7 pcLoad", 32'(pcLoad), 32'd1);
    check("R7 return address", 32'(pcOut), 32'h123);
    rdCheck("R7 gie set sp inc", 8'hDF, 8'h87);
    tick();
    check("R5 reentry vector", 32'(pcOut), 32'h008);
    check("R9 index five", 32'(irqIndex), 32'd5);
    rdCheck("R5 sp dec again", 8'hDF, 8'h06);
    wrReg(8'hC8, 8'h00);
    ret();
    check("R7 second return", 32'(pcOut), 32'h200);
    rdCheck("R7 reg after return", 8'hDF, 8'h87);

    // R8: wrap both ways
    wrReg(8'hDF, 8'h00);
    rdCheck("R12 bits cleared", 8'hDF, 8'h00);
    reqIn[0] = 1'b1;
    tick();
    rdCheck("R2 bit1", 8'hC8, 8'h02);
    nextPc = 12'h0AB;
    wrReg(8'hDF, 8'h80);
    tick();
    check("R8 entry vector", 32'(pcOut), 32'h008);
    check("R9 index one", 32'(irqIndex), 32'd1);
    rdCheck("R8 sp wraps to 7", 8'hDF, 8'h07);
    wrReg(8'hC8, 8'h00);
    ret();
    check("R8 return address", 32'(pcOut), 32'h0AB);
    rdCheck("R8 sp wraps to 0", 8'hDF, 8'h80);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule